// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block serialises characters onto a single output line that idles high. In front of the output shift register sits a one-entry holding register. Software-style logic writes a character into the holding register while the buffer-empty flag is set. The holding register passes its character to the shift register either when the shifter is idle or at the baud tick that ends the last bit of the frame in progress. Characters therefore run back to back with no idle gap. The ninth bit of a 9-bit character comes from a separate latch. A done flag reports that the line has drained completely.

Two framings are offered. The asynchronous framing sends a low start bit, then 5 to 9 data bits least significant first, then one or two high stop bits. The master synchronous framing sends exactly eight data bits, most or least significant first, with no start or stop bits. It also drives a shift clock that idles low, rises in the middle of each bit and falls where the data changes. All bit timing comes from an external baud tick pulse. Dropping the enable does not cut a transfer short: the line stays driven until both registers are empty, and then it is released.

Top module: `sertx_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `txd` is 1, `txd_oe` is 0, `sclk` is 0, `tx_done` is 0 and `dre` follows `tx_enable` (buffer empty).
- R2: In asynchronous mode (`cfg_sync`=0) a frame is one 0 bit, then the data bits least significant first, then one 1 bit (`cfg_two_stop`=0) or two 1 bits (`cfg_two_stop`=1). Each bit starts at a baud tick and is held until the next baud tick.
- R3: `cfg_size` gives the asynchronous character length. Values 5 to 9 are used as given, values below 5 act as 5 and values above 9 act as 9. Bits of the written character at or above that length are never sent.
- R4: The ninth data bit is the value of the `wr_bit8` latch at the cycle of the accepted `wr_data_en` write. Changing the latch afterwards does not alter a character that is already buffered or shifting.
- R5: `dre` is 1 exactly when `tx_enable` is 1 and the holding register is empty. A `wr_data_en` pulse while `dre` is 0 is ignored.
- R6: A buffered character starts at the first baud tick while the shifter is idle. A character buffered during a frame starts at the baud tick that ends that frame's last bit, with no idle bit in between.
- R7: `tx_done` rises one cycle after the baud tick that ends a frame while the holding register is empty. It is cleared by `clr_done` or by an accepted write, and a clear in the same cycle as the ending frame takes priority.
- R8: When `tx_enable` falls, the current and the buffered frame are still sent. `txd_oe` stays 1 while either register holds data and falls only after both are empty, and `txd` is then 1.
- R9: In synchronous mode (`cfg_sync`=1) a frame is exactly 8 data bits with no start or stop bits. The order is most significant first when `cfg_msb_first`=1 and least significant first otherwise, and `txd` is 1 between frames.
- R10: In synchronous mode each bit lasts two baud tick periods. `sclk` is 0 for the first and 1 for the second period. `sclk` is 0 whenever no frame is shifting, and it only changes at a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse marking a bit (or half-bit in synchronous mode) boundary |
| cfg_sync | input | 1 | 1 selects master synchronous framing |
| cfg_msb_first | input | 1 | Synchronous bit order, 1 = most significant first |
| cfg_size | input | 4 | Asynchronous character length in bits |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_enable | input | 1 | Transmitter enable request |
| wr_data_en | input | 1 | Write strobe for the low byte |
| wr_data | input | 8 | Low byte of the character |
| wr_bit8_en | input | 1 | Write strobe for the ninth-bit latch |
| wr_bit8 | input | 1 | Ninth-bit value |
| clr_done | input | 1 | Clears `tx_done` |
| dre | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Line has drained with nothing pending |
| txd | output | 1 | Serial data line |
| txd_oe | output | 1 | Drive enable for the data line |
| sclk | output | 1 | Synchronous shift clock |

## Verification
On every cycle the assertions check four things. The data line and the shift clock move only at baud ticks. A frame starts only on a tick. A buffered character stays unchanged until the shifter takes it. The line stays driven and the done flag stays low while either register is busy. The actual bit sequences, the truncation of short characters, the ninth-bit sampling point, back-to-back handoff with no gap and the deferred release after disable can only be shown by the bench scenarios. The bench compares these against its behavioural model on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int CHAR_MAX  = DATA_W + 1;
    localparam int CHAR_MIN  = 5;
    localparam int SYNC_BITS = 8;
    localparam int FRAME_W   = 1 + CHAR_MAX + 2;
    localparam int LEN_W     = $clog2(FRAME_W + 1);
    localparam int SIZE_W    = $clog2(CHAR_MAX + 1);

    typedef logic [CHAR_MAX-1:0] char_t;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic              msb_first;
        logic [SIZE_W-1:0] size;
        logic              two_stop;
    } cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic int clamp_size(logic [SIZE_W-1:0] s);
        int v;
        v = int'(s);
        if (v < CHAR_MIN) v = CHAR_MIN;
        if (v > CHAR_MAX) v = CHAR_MAX;
        return v;
    endfunction

    // Bit 0 of the result leaves the line first.
    function automatic frame_t build_frame(char_t c, cfg_t cfg);
        frame_t f;
        int     n;
        f.bits = '1;
        if (cfg.mode == MODE_SYNC) begin
            for (int i = 0; i < SYNC_BITS; i++)
                f.bits[i] = cfg.msb_first ? c[SYNC_BITS-1-i] : c[i];
            f.len = LEN_W'(SYNC_BITS);
        end else begin
            n = clamp_size(cfg.size);
            f.bits[0] = 1'b0;
            for (int i = 0; i < CHAR_MAX; i++)
                if (i < n) f.bits[i+1] = c[i];
            f.len = LEN_W'(1 + n + (cfg.two_stop ? 2 : 1));
        end
        return f;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_req,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              bit8_wr,
    input  logic              bit8_val,
    input  logic              take,
    output logic              full,
    output logic              accepted,
    output logic              dre,
    output char_t             char_q
);

    logic full_q;
    logic bit8_q;

    assign dre      = en_req & ~full_q;
    assign accepted = wr_en & dre;
    assign full     = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            bit8_q <= 1'b0;
            char_q <= '0;
        end else begin
            if (bit8_wr)
                bit8_q <= bit8_val;
            if (take)
                full_q <= 1'b0;
            if (accepted) begin
                full_q <= 1'b1;
                char_q <= {bit8_q, wr_byte};
            end
        end
    end

    // R5: a buffered character is neither lost nor overwritten until taken
    a_r5_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
        (full_q && !take) |=> (full_q && $stable(char_q)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  cfg_t  cfg,
    input  logic  have_data,
    input  char_t char_in,
    output logic  take,
    output logic  frame_end,
    output logic  active,
    output logic  txd,
    output logic  sclk
);

    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   left_q;
    logic               active_q;
    logic               phase_q;
    logic               first_half;
    logic               last_bit;
    frame_t             next_f;

    always_comb begin
        next_f     = build_frame(char_in, cfg);
        first_half = (cfg.mode == MODE_SYNC) && !phase_q;
        last_bit   = (left_q == LEN_W'(1));
        take       = tick && have_data && (!active_q || (!first_half && last_bit));
        frame_end  = tick && active_q && !first_half && last_bit && !have_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '1;
            left_q   <= '0;
            active_q <= 1'b0;
            phase_q  <= 1'b0;
        end else if (take) begin
            sh_q     <= next_f.bits;
            left_q   <= next_f.len;
            active_q <= 1'b1;
            phase_q  <= 1'b0;
        end else if (tick && active_q) begin
            if (first_half) begin
                phase_q <= 1'b1;
            end else if (last_bit) begin
                active_q <= 1'b0;
                phase_q  <= 1'b0;
                sh_q     <= '1;
            end else begin
                sh_q    <= {1'b1, sh_q[FRAME_W-1:1]};
                left_q  <= left_q - LEN_W'(1);
                phase_q <= 1'b0;
            end
        end
    end

    assign active = active_q;
    assign txd    = active_q ? sh_q[0] : 1'b1;
    assign sclk   = active_q && phase_q && (cfg.mode == MODE_SYNC);

    // R2: the line only moves at a baud tick while shifting
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q) && !$past(tick)) |-> $stable(txd));

    // R10: the shift clock only changes at a baud tick
    a_r10_sclk_on_tick_only: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(sclk));

    // R6: a frame begins only on a baud tick
    a_r6_start_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> $past(tick));

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic busy,
    input  logic accepted,
    input  logic clr,
    input  logic frame_end,
    output logic en_q,
    output logic done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            en_q <= en_req | busy;
            if (accepted || clr)
                done_q <= 1'b0;
            else if (frame_end)
                done_q <= 1'b1;
        end
    end

    // R8: the line stays driven while anything is queued or shifting
    a_r8_enable_held_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> en_q);

    // R7: done never coexists with queued or shifting data
    a_r7_done_only_when_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy);

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              cfg_sync,
    input  logic              cfg_msb_first,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_two_stop,
    input  logic              tx_enable,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8_en,
    input  logic              wr_bit8,
    input  logic              clr_done,
    output logic              dre,
    output logic              tx_done,
    output logic              txd,
    output logic              txd_oe,
    output logic              sclk
);

    cfg_t  cfg;
    char_t held_char;
    logic  buf_full;
    logic  buf_accepted;
    logic  sh_take;
    logic  sh_end;
    logic  sh_active;

    always_comb begin
        cfg.mode      = cfg_sync ? MODE_SYNC : MODE_ASYNC;
        cfg.msb_first = cfg_msb_first;
        cfg.size      = cfg_size;
        cfg.two_stop  = cfg_two_stop;
    end

    sertx_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .en_req   (tx_enable),
        .wr_en    (wr_data_en),
        .wr_byte  (wr_data),
        .bit8_wr  (wr_bit8_en),
        .bit8_val (wr_bit8),
        .take     (sh_take),
        .full     (buf_full),
        .accepted (buf_accepted),
        .dre      (dre),
        .char_q   (held_char)
    );

    sertx_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .cfg       (cfg),
        .have_data (buf_full),
        .char_in   (held_char),
        .take      (sh_take),
        .frame_end (sh_end),
        .active    (sh_active),
        .txd       (txd),
        .sclk      (sclk)
    );

    sertx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en_req    (tx_enable),
        .busy      (buf_full | sh_active),
        .accepted  (buf_accepted),
        .clr       (clr_done),
        .frame_end (sh_end),
        .en_q      (txd_oe),
        .done_q    (tx_done)
    );

endmodule

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_sync = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [3:0] cfg_size = 4'd8;
    logic       cfg_two_stop = 1'b0;
    logic       tx_enable = 1'b0;
    logic       wr_data_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bit8_en = 1'b0;
    logic       wr_bit8 = 1'b0;
    logic       clr_done = 1'b0;
    logic       dre, tx_done, txd, txd_oe, sclk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string txd_tag = "R2";

    sertx_core dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .cfg_sync(cfg_sync), .cfg_msb_first(cfg_msb_first),
        .cfg_size(cfg_size), .cfg_two_stop(cfg_two_stop),
        .tx_enable(tx_enable), .wr_data_en(wr_data_en), .wr_data(wr_data),
        .wr_bit8_en(wr_bit8_en), .wr_bit8(wr_bit8), .clr_done(clr_done),
        .dre(dre), .tx_done(tx_done), .txd(txd), .txd_oe(txd_oe), .sclk(sclk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    bit       q[$];
    bit       m_full = 0, m_active = 0, m_phase = 0, m_txc = 0, m_en = 0, m_bit8 = 0;
    bit [8:0] m_char = '0;

    function automatic void load_bits(bit [8:0] c);
        int n;
        q.delete();
        if (cfg_sync) begin
            for (int i = 0; i < 8; i++) q.push_back(cfg_msb_first ? c[7-i] : c[i]);
        end else begin
            n = int'(cfg_size);
            if (n < 5) n = 5;
            if (n > 9) n = 9;
            q.push_back(1'b0);
            for (int i = 0; i < n; i++) q.push_back(c[i]);
            q.push_back(1'b1);
            if (cfg_two_stop) q.push_back(1'b1);
        end
    endfunction

    always @(posedge clk) begin
        bit old_full, old_active, acc, take, fin;
        if (rst) begin
            m_full = 0; m_active = 0; m_phase = 0; m_txc = 0; m_en = 0; m_bit8 = 0;
            q.delete();
        end else begin
            old_full   = m_full;
            old_active = m_active;
            acc  = wr_data_en && tx_enable && !m_full;
            take = 0;
            fin  = 0;
            if (baud_tick) begin
                if (m_active) begin
                    if (cfg_sync && !m_phase) m_phase = 1;
                    else begin
                        m_phase = 0;
                        void'(q.pop_front());
                        if (q.size() == 0) begin
                            if (old_full) take = 1;
                            else begin m_active = 0; fin = 1; end
                        end
                    end
                end else if (old_full) take = 1;
            end
            if (take) begin
                load_bits(m_char);
                m_active = 1; m_phase = 0; m_full = 0;
            end
            if (acc) begin m_full = 1; m_char = {m_bit8, wr_data}; end
            if (wr_bit8_en) m_bit8 = wr_bit8;
            if (acc || clr_done) m_txc = 0;
            else if (fin) m_txc = 1;
            m_en = tx_enable || old_full || old_active;
        end
    end

    // baud tick generator, driven away from the edge
    always @(posedge clk) begin
        #3;
        baud_tick = ((cycles % TICK_DIV) == 0);
    end

    task automatic check(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, name, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            check("R1", "txd",    txd,     1'b1);
            check("R1", "txd_oe", txd_oe,  1'b0);
            check("R1", "sclk",   sclk,    1'b0);
            check("R1", "tx_done",tx_done, 1'b0);
        end else begin
            check(txd_tag, "txd", txd, m_active ? q[0] : 1'b1);
            check("R8",  "txd_oe",  txd_oe,  m_en);
            check("R10", "sclk",    sclk,    m_active && cfg_sync && m_phase);
            check("R5",  "dre",     dre,     tx_enable && !m_full);
            check("R7",  "tx_done", tx_done, m_txc);
        end
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(posedge clk);
        #3;
        wr_data_en = 0;
        wr_bit8_en = 0;
        clr_done   = 0;
    endtask

    task automatic idle(int n);
        repeat (n) cyc();
    endtask

    task automatic put(logic [7:0] d);
        cyc();
        wr_data_en = 1;
        wr_data    = d;
    endtask

    task automatic drain();
        while (m_full || m_active) cyc();
        idle(3);
    endtask

    initial begin
        idle(3);
        rst = 0;
        cyc();
        // R1: first cycle out of reset
        check("R1", "dre_after_reset", dre, 1'b0);

        // R2 / R6: async 8N1, back to back, ignored third write (R5)
        tx_enable = 1;
        cyc();
        txd_tag = "R6";
        put(8'hA5);
        idle(6);
        put(8'h3C);
        put(8'hFF);
        idle(2);
        put(8'h11);
        drain();
        // R7: done after drain, clear by clr_done
        check("R7", "done_set", tx_done, 1'b1);
        cyc();
        clr_done = 1;
        cyc();
        check("R7", "done_cleared", tx_done, 1'b0);

        // R3: short characters, two stop bits, out-of-range sizes
        txd_tag = "R3";
        cfg_size = 4'd5; cfg_two_stop = 1;
        put(8'hFF);
        put(8'hE2);
        drain();
        cfg_size = 4'd6; cfg_two_stop = 0;
        put(8'hEA);
        drain();
        cfg_size = 4'd2;
        put(8'hD6);
        drain();

        // R4: ninth bit latched at the low-byte write
        txd_tag = "R4";
        cfg_size = 4'd9;
        cyc(); wr_bit8_en = 1; wr_bit8 = 1;
        put(8'h55);
        cyc(); wr_bit8_en = 1; wr_bit8 = 0;
        put(8'h0F);
        drain();
        cfg_size = 4'd15;
        cyc(); wr_bit8_en = 1; wr_bit8 = 1;
        put(8'h80);
        drain();

        // R8: disable waits for both registers to empty
        txd_tag = "R8";
        cfg_size = 4'd8;
        put(8'h96);
        put(8'h69);
        cyc();
        tx_enable = 0;
        put(8'h77);
        drain();
        check("R8", "released_oe", txd_oe, 1'b0);
        check("R8", "released_txd", txd, 1'b1);

        // R9 / R10: synchronous mode, msb first, back to back
        txd_tag = "R9";
        cfg_sync = 1; cfg_msb_first = 1;
        tx_enable = 1;
        cyc();
        put(8'h96);
        idle(4);
        put(8'h5A);
        drain();
        // lsb first, then a gap and a second frame
        cfg_msb_first = 0;
        put(8'hC3);
        drain();
        put(8'h01);
        drain();
        check("R10", "sclk_idle", sclk, 1'b0);

        // R7: clear by write in the cycle the frame ends wins
        txd_tag = "R2";
        cfg_sync = 0;
        put(8'h33);
        while (!(m_active && q.size() == 1 && cycles % TICK_DIV == TICK_DIV - 1)) cyc();
        put(8'h44);
        drain();

        idle(4);
        finish_run();
    end

endmodule